// File: doc/BRIEF.md
# Suspend Modulation Clock Throttle Controller

This block lowers the effective speed of a processor by driving its active-low suspend input on and off. While modulation is enabled, the block alternates between a run phase, in which the suspend output is released, and a suspend phase, in which it is driven low so the processor idles. Each phase lasts a programmed number of ticks. One tick is a fixed 32 µs interval, derived from the system clock by a parameterised prescaler. The processor therefore runs at a fraction run/(run+suspend) of its full speed.

Two speedup timers, one for interrupt activity and one for video activity, can override the throttle. An event pulse on either input reloads its timer, provided that speedup source is enabled. While either timer is nonzero, the suspend output stays released. The timers count down in 1 ms steps, each step being a fixed number of ticks. When both timers reach zero, modulation starts again from the beginning of a run phase.

All settings sit in a byte-wide register file with a single write/read port. The settings are the two phase counts, the modulation configuration, the power-management enables and the two speedup reload values. A new phase count takes effect only at the next phase boundary.

Top module: `susp_throttle`

## Requirements
- R1: After reset, every register reads 0x00, both speedup timers are idle, and `susp_n` is 1.
- R2: The six registers are at these addresses: 0x80 power-management enable, 0x8C interrupt speedup reload, 0x8D video speedup reload, 0x94 run count, 0x95 suspend count and 0x96 modulation configuration. Each register reads back the last byte written to it. Any other address reads 0x00.
- R3: While bit 0 of the configuration register (0x96) is 0, `susp_n` stays 1.
- R4: In steady modulation with both counts nonzero, each low interval of `susp_n` lasts (suspend count × CYC_PER_TICK) clock cycles. Each high interval lasts (run count × CYC_PER_TICK) clock cycles.
- R5: Over any window of whole modulation periods, the fraction of cycles with `susp_n` low equals suspend/(run+suspend).
- R6: With a suspend count of 0, `susp_n` is never driven low. Every fall of `susp_n` follows a cycle in which the suspend count was nonzero.
- R7: With a run count of 0 and a nonzero suspend count, `susp_n` stays low continuously, except while speedup is active.
- R8: A write to a phase count during a phase changes neither the length of that phase nor the output during it. The new value applies from the next phase boundary.
- R9: A one-cycle pulse on `irq_evt` loads the interrupt timer with its reload value (in ms) when 0x80 bit 0 and bit 3 are both 1. A pulse on `vid_evt` does the same for the video timer when bit 0 and bit 4 are both 1. While either timer is nonzero, `susp_n` is 1. One ms equals TICKS_PER_MS ticks.
- R10: An event pulse has no effect on `susp_n` if its source bit (bit 3 or bit 4) is 0, or if global bit 0 of 0x80 is 0.
- R11: When the last speedup timer expires, modulation restarts with a complete run phase before the next suspend phase. If the run count is 0, it restarts directly in suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request to the processor |

## Verification
The bench measures the exact lengths of low and high intervals, so a design that reloads a phase one tick early or late, or that counts down to zero and then spends an extra tick there, shows a wrong length. It rewrites the suspend count in the middle of a suspend phase. A design that reads the count live instead of latching it at the boundary cuts that phase short. After a speedup it checks that the output stays high long enough to cover a full run phase. A design that resumes the interrupted suspend phase goes low too early. It also checks the zero-count corners and the gating by the global and per-source enable bits. A design that ignores either enable bit lets a stray event release a processor held in continuous suspend.

// File: rtl/sm_pkg.sv
package sm_pkg;

    localparam int DW = 8;

    localparam logic [7:0] ADDR_PME     = 8'h80;
    localparam logic [7:0] ADDR_IRQ_RLD = 8'h8C;
    localparam logic [7:0] ADDR_VID_RLD = 8'h8D;
    localparam logic [7:0] ADDR_RUN     = 8'h94;
    localparam logic [7:0] ADDR_SUSP    = 8'h95;
    localparam logic [7:0] ADDR_CFG     = 8'h96;

    localparam int PME_GLOBAL_BIT = 0;
    localparam int PME_IRQ_BIT    = 3;
    localparam int PME_VID_BIT    = 4;
    localparam int CFG_MOD_BIT    = 0;

    localparam int NUM_SPD = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_SUSP = 2'd2
    } phase_e;

    typedef struct packed {
        logic [DW-1:0] pme;
        logic [DW-1:0] irq_rld;
        logic [DW-1:0] vid_rld;
        logic [DW-1:0] run_cnt;
        logic [DW-1:0] susp_cnt;
        logic [DW-1:0] cfg;
    } regs_t;

    typedef struct packed {
        phase_e        ph;
        logic [DW-1:0] left;
    } phase_t;

    // Choose the next phase, skipping one whose count is zero.
    function automatic phase_t phase_pick(input logic want_susp,
                                          input logic [DW-1:0] susp_c,
                                          input logic [DW-1:0] run_c);
        phase_t p;
        if (want_susp && susp_c != '0) begin
            p.ph = PH_SUSP; p.left = susp_c;
        end else if (run_c != '0) begin
            p.ph = PH_RUN;  p.left = run_c;
        end else if (susp_c != '0) begin
            p.ph = PH_SUSP; p.left = susp_c;
        end else begin
            p.ph = PH_RUN;  p.left = '0;
        end
        return p;
    endfunction

endpackage

// File: rtl/sm_regs.sv
module sm_regs
    import sm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wdata,
    output regs_t         regs,
    output logic [DW-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr) begin
            case (addr)
                ADDR_PME:     regs.pme      <= wdata;
                ADDR_IRQ_RLD: regs.irq_rld  <= wdata;
                ADDR_VID_RLD: regs.vid_rld  <= wdata;
                ADDR_RUN:     regs.run_cnt  <= wdata;
                ADDR_SUSP:    regs.susp_cnt <= wdata;
                ADDR_CFG:     regs.cfg      <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_PME:     rdata = regs.pme;
            ADDR_IRQ_RLD: rdata = regs.irq_rld;
            ADDR_VID_RLD: rdata = regs.vid_rld;
            ADDR_RUN:     rdata = regs.run_cnt;
            ADDR_SUSP:    rdata = regs.susp_cnt;
            ADDR_CFG:     rdata = regs.cfg;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/sm_prescale.sv
module sm_prescale #(
    parameter int CYC_PER_TICK = 4000,
    parameter int TICKS_PER_MS = 31
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic ms_stb
);

    localparam int CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
    localparam int MW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_TICK - 1);
    localparam logic [MW-1:0] MS_LAST  = MW'(TICKS_PER_MS - 1);

    logic [CW-1:0] cyc_q;
    logic [MW-1:0] tk_q;

    assign tick   = (cyc_q == CYC_LAST);
    assign ms_stb = tick && (tk_q == MS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            tk_q  <= '0;
        end else begin
            cyc_q <= tick ? '0 : cyc_q + 1'b1;
            if (tick) tk_q <= (tk_q == MS_LAST) ? '0 : tk_q + 1'b1;
        end
    end

endmodule

// File: rtl/sm_speedup_tmr.sv
module sm_speedup_tmr
    import sm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic          en,
    input  logic [DW-1:0] reload,
    input  logic          ms_stb,
    output logic          active
);

    logic [DW-1:0] cnt_q;

    assign active = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (trig && en)      cnt_q <= reload;
        else if (ms_stb && active) cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/sm_phase.sv
module sm_phase
    import sm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          mod_en,
    input  logic          hold,
    input  logic [DW-1:0] susp_c,
    input  logic [DW-1:0] run_c,
    output logic          susp
);

    phase_t st_q;

    assign susp = (st_q.ph == PH_SUSP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_IDLE, left: '0};
        end else if (!mod_en || hold) begin
            st_q <= '{ph: PH_IDLE, left: '0};
        end else if (st_q.ph == PH_IDLE) begin
            st_q <= phase_pick(1'b0, susp_c, run_c);
        end else if (tick) begin
            if (st_q.left > 1) st_q.left <= st_q.left - 1'b1;
            else               st_q <= phase_pick(st_q.ph == PH_RUN, susp_c, run_c);
        end
    end

endmodule

// File: rtl/susp_throttle.sv
module susp_throttle
    import sm_pkg::*;
#(
    parameter int CYC_PER_TICK = 4000,
    parameter int TICKS_PER_MS = 31
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_evt,
    input  logic       vid_evt,
    output logic       susp_n
);

    regs_t               regs;
    logic                tick, ms_stb;
    logic                mod_en, spd_any, susp_int;
    logic [NUM_SPD-1:0]  evt, src_en, act;
    logic [DW-1:0]       rld [NUM_SPD];

    sm_regs i_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .regs(regs), .rdata(reg_rdata)
    );

    sm_prescale #(.CYC_PER_TICK(CYC_PER_TICK), .TICKS_PER_MS(TICKS_PER_MS)) i_pre (
        .clk(clk), .rst(rst), .tick(tick), .ms_stb(ms_stb)
    );

    assign evt    = {vid_evt, irq_evt};
    assign src_en = {regs.pme[PME_VID_BIT], regs.pme[PME_IRQ_BIT]} &
                    {NUM_SPD{regs.pme[PME_GLOBAL_BIT]}};
    assign rld[0] = regs.irq_rld;
    assign rld[1] = regs.vid_rld;

    for (genvar g = 0; g < NUM_SPD; g++) begin : g_spd
        sm_speedup_tmr i_tmr (
            .clk(clk), .rst(rst), .trig(evt[g]), .en(src_en[g]),
            .reload(rld[g]), .ms_stb(ms_stb), .active(act[g])
        );
    end

    assign spd_any = |act;
    assign mod_en  = regs.cfg[CFG_MOD_BIT];

    sm_phase i_phase (
        .clk(clk), .rst(rst), .tick(tick), .mod_en(mod_en), .hold(spd_any),
        .susp_c(regs.susp_cnt), .run_c(regs.run_cnt), .susp(susp_int)
    );

    assign susp_n = ~(susp_int & ~spd_any & mod_en);

endmodule

// File: rtl/sm_throttle_chk.sv
module sm_throttle_chk (
    input logic       clk,
    input logic       rst,
    input logic       susp_n,
    input logic       mod_en,
    input logic       spd_any,
    input logic [7:0] susp_c,
    input logic [7:0] run_c
);

    p_disabled_run_r3: assert property (@(posedge clk) disable iff (rst)
        !mod_en |-> susp_n);

    p_speedup_run_r9: assert property (@(posedge clk) disable iff (rst)
        spd_any |-> susp_n);

    p_fall_needs_count_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(susp_n) |-> $past(susp_c) != 8'd0);

    p_restart_in_run_r11: assert property (@(posedge clk) disable iff (rst)
        ($fell(spd_any) && mod_en && run_c != 8'd0) |=> susp_n);

endmodule

bind susp_throttle sm_throttle_chk i_chk (
    .clk(clk), .rst(rst), .susp_n(susp_n), .mod_en(mod_en),
    .spd_any(spd_any), .susp_c(regs.susp_cnt), .run_c(regs.run_cnt)
);

// File: tb/test_susp_throttle.sv
module test_susp_throttle;

    localparam int TCK = 2;
    localparam int TPM = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_evt = 1'b0;
    logic       vid_evt = 1'b0;
    logic       susp_n;

    int checks = 0;
    int fails  = 0;

    susp_throttle #(.CYC_PER_TICK(TCK), .TICKS_PER_MS(TPM)) i_susp_throttle (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_evt(irq_evt), .vid_evt(vid_evt), .susp_n(susp_n)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic setup(input logic [7:0] pme, input logic [7:0] run_c,
                         input logic [7:0] susp_c, input logic [7:0] cfg);
        wr(8'h96, 8'h00);
        wr(8'h80, pme);
        wr(8'h94, run_c);
        wr(8'h95, susp_c);
        wr(8'h96, cfg);
    endtask

    task automatic sync_fall();
        int g = 0;
        while (susp_n !== 1'b1 && g < 2000) begin @(negedge clk); g++; end
        while (susp_n !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
    endtask

    task automatic low_run(output int n);
        n = 0;
        while (susp_n === 1'b0 && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic high_run(output int n);
        n = 0;
        while (susp_n === 1'b1 && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic count_high(input int cyc, output int n);
        n = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (susp_n === 1'b1) n++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(susp_n === 1'b1, "R1 susp_n after reset", susp_n, 1);
        rd(8'h80, 8'h00, "R1 pme reset");
        rd(8'h94, 8'h00, "R1 run reset");
        rd(8'h95, 8'h00, "R1 susp reset");
        rd(8'h96, 8'h00, "R1 cfg reset");
    endtask

    task automatic t_readback();
        wr(8'h80, 8'h5A); wr(8'h8C, 8'h04); wr(8'h8D, 8'h64);
        wr(8'h94, 8'hC3); wr(8'h95, 8'h3C); wr(8'h96, 8'hFE);
        rd(8'h80, 8'h5A, "R2 pme");
        rd(8'h8C, 8'h04, "R2 irq reload");
        rd(8'h8D, 8'h64, "R2 vid reload");
        rd(8'h94, 8'hC3, "R2 run count");
        rd(8'h95, 8'h3C, "R2 susp count");
        rd(8'h96, 8'hFE, "R2 cfg");
        rd(8'h81, 8'h00, "R2 unmapped");
    endtask

    task automatic t_disabled();
        int n;
        setup(8'h00, 8'd3, 8'd5, 8'h00);
        count_high(60, n);
        chk(n == 60, "R3 disabled stays high", n, 60);
    endtask

    task automatic t_phase_len();
        int n;
        setup(8'h00, 8'd2, 8'd3, 8'h01);
        sync_fall();
        low_run(n);
        chk(n == 3*TCK, "R4 suspend length", n, 3*TCK);
        high_run(n);
        chk(n == 2*TCK, "R4 run length", n, 2*TCK);
        sync_fall();
        count_high(100, n);
        chk(100 - n == 60, "R5 duty over ten periods", 100 - n, 60);
    endtask

    task automatic t_susp_zero();
        int n;
        setup(8'h00, 8'd4, 8'd0, 8'h01);
        count_high(60, n);
        chk(n == 60, "R6 zero suspend count never low", n, 60);
    endtask

    task automatic t_run_zero();
        int n;
        setup(8'h00, 8'd0, 8'd3, 8'h01);
        repeat (10) @(negedge clk);
        count_high(60, n);
        chk(n == 0, "R7 zero run count always low", n, 0);
    endtask

    task automatic t_midwrite();
        int n;
        setup(8'h00, 8'd4, 8'd4, 8'h01);
        sync_fall();
        n = 0;
        while (susp_n === 1'b0 && n < 2000) begin
            n++;
            if (n == 2) begin reg_wr = 1'b1; reg_addr = 8'h95; reg_wdata = 8'd1; end
            if (n == 3) reg_wr = 1'b0;
            @(negedge clk);
        end
        reg_wr = 1'b0;
        chk(n == 4*TCK, "R8 current phase unchanged by write", n, 4*TCK);
        sync_fall();
        low_run(n);
        chk(n == 1*TCK, "R8 new count at next phase", n, 1*TCK);
    endtask

    task automatic t_irq_speedup();
        int n, w;
        wr(8'h8C, 8'd2);
        setup(8'h09, 8'd5, 8'd10, 8'h01);
        sync_fall();
        irq_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0;
        count_high(16, n);
        chk(n == 16, "R9 irq speedup holds run", n, 16);
        chk(n == 16, "R11 full run phase after speedup", n, 16);
        w = 0;
        while (susp_n === 1'b1 && w < 30) begin @(negedge clk); w++; end
        chk(susp_n === 1'b0, "R11 modulation resumes", susp_n, 0);
    endtask

    task automatic t_vid_speedup();
        int n, w;
        wr(8'h8D, 8'd3);
        setup(8'h11, 8'd0, 8'd3, 8'h01);
        repeat (6) @(negedge clk);
        vid_evt = 1'b1;
        @(negedge clk);
        vid_evt = 1'b0;
        count_high(12, n);
        chk(n == 12, "R9 video speedup holds run", n, 12);
        w = 0;
        while (susp_n === 1'b1 && w < 25) begin @(negedge clk); w++; end
        chk(susp_n === 1'b0, "R11 restart in suspend when run count zero", susp_n, 0);
    endtask

    task automatic t_gated();
        int n;
        wr(8'h8C, 8'd3);
        wr(8'h8D, 8'd3);
        setup(8'h18, 8'd0, 8'd3, 8'h01);
        repeat (6) @(negedge clk);
        irq_evt = 1'b1; vid_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0; vid_evt = 1'b0;
        count_high(20, n);
        chk(n == 0, "R10 global enable clear blocks events", n, 0);
        wr(8'h80, 8'h01);
        irq_evt = 1'b1; vid_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0; vid_evt = 1'b0;
        count_high(20, n);
        chk(n == 0, "R10 source bits clear block events", n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_disabled();
        t_phase_len();
        t_susp_zero();
        t_run_zero();
        t_midwrite();
        t_irq_speedup();
        t_vid_speedup();
        t_gated();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule